// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block holds the on/off state of a 4x4 crosspoint matrix that is built twice, as a primary plane and a mirrored plane. A 4-bit address names one of the 16 crosspoints. On a clock edge where the write strobe is high, the named crosspoint's storage bit takes the data bit. Every stored bit closes the same crosspoint in both planes, so the two enable vectors are always identical.

Two global controls act on the whole store. Clear opens every crosspoint. Set closes every crosspoint. Clear wins over set, and both win over a strobe write. From the stored state the block also derives a route map. For each Y line, the map gives the lowest-numbered X line that is connected to it, a flag that says whether any connection exists, and a flag that says whether more than one X line is connected. Fan-in on a Y line is allowed; it is reported, not blocked.

Top module: `xp_ctrl_mem`

## Requirements
- R1: A synchronous active-high `rst` drives both enable vectors, `route_hit` and `multi_x` to all zeros.
- R2: Address decode. `addr[1:0]` picks the X line and `addr[3:2]` picks the Y line. The low bit of each pair is the least significant bit, so `addr[1:0]`=1 means X2 and `addr[3:2]`=2 means Y3. The crosspoint for X line x and Y line y (both counted from 0) sits at bit y*4+x of each enable vector.
- R3: When `strobe` is high at a rising edge and neither global control is high, the addressed bit takes `din`. The change shows on the enable outputs right after that edge.
- R4: Bits that are not addressed keep their value. When `strobe`, `gset` and `gclr` are all low, no bit changes.
- R5: `en_mirror` equals `en_main` at all times.
- R6: `gclr` high at an edge clears every bit. This happens whatever the values of `gset` and `strobe`.
- R7: `gset` high with `gclr` low sets every bit. This happens whatever the value of `strobe`.
- R8: The route outputs are registered one clock after the enable vector. `route_hit[y]` is 1 when any crosspoint on Y line y is closed. `route_x[2y+1:2y]` gives the lowest closed X index on that line, and reads 0 when no crosspoint on the line is closed.
- R9: `multi_x[y]` is 1 when two or more crosspoints on Y line y are closed. It follows the same one-clock lag as the route outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Crosspoint address: [1:0] selects X, [3:2] selects Y |
| din | input | 1 | Bit written to the addressed crosspoint |
| strobe | input | 1 | Write strobe, sampled on the clock |
| gset | input | 1 | Close all crosspoints |
| gclr | input | 1 | Open all crosspoints (highest priority) |
| en_main | output | 16 | Primary-plane switch enables, bit y*4+x |
| en_mirror | output | 16 | Mirrored-plane switch enables |
| route_x | output | 8 | Lowest closed X index per Y line, 2 bits per line |
| route_hit | output | 4 | Per Y line: at least one crosspoint closed |
| multi_x | output | 4 | Per Y line: more than one crosspoint closed |

## Verification
The hardest states to reach are those where the controls conflict. One case is clear, set and a strobe write all high on the same edge. Another is set and a write together, where the written bit is 0 and so runs against the global control. The stimulus table puts these combinations on single edges. It lands them on stores that are partly filled, so a wrong priority would leave a visible pattern rather than all zeros. The table also closes a second X line on a Y line that already has one. A later write then removes the lower X line, so both the change in the priority encoder and the clearing of the fan-in flag get checked.

// File: rtl/xp_pkg.sv
package xp_pkg;

  // Store operation after priority resolution
  typedef enum logic [1:0] {
    XP_HOLD  = 2'd0,
    XP_WRITE = 2'd1,
    XP_SET   = 2'd2,
    XP_CLEAR = 2'd3
  } xp_op_e;

  // Clear beats set, set beats a strobe write
  function automatic xp_op_e xp_resolve(input logic strobe, input logic gset,
                                        input logic gclr);
    if (gclr)        return XP_CLEAR;
    else if (gset)   return XP_SET;
    else if (strobe) return XP_WRITE;
    else             return XP_HOLD;
  endfunction

endpackage

// File: rtl/xp_addr_dec.sv
module xp_addr_dec #(
  parameter int X_LINES = 4,
  parameter int Y_LINES = 4,
  localparam int XW     = $clog2(X_LINES),
  localparam int YW     = $clog2(Y_LINES),
  localparam int NODES  = X_LINES * Y_LINES
) (
  input  logic [XW+YW-1:0] addr,
  output logic [NODES-1:0] sel
);

  logic [XW-1:0] x_idx;
  logic [YW-1:0] y_idx;

  assign x_idx = addr[XW-1:0];
  assign y_idx = addr[XW +: YW];

  // One-hot select; node (x, y) lives at y*X_LINES + x
  always_comb begin
    sel = '0;
    for (int y = 0; y < Y_LINES; y++) begin
      for (int x = 0; x < X_LINES; x++) begin
        if (int'(x_idx) == x && int'(y_idx) == y) sel[y*X_LINES + x] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xp_store.sv
module xp_store
  import xp_pkg::*;
#(
  parameter int NODES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  xp_op_e           op,
  input  logic [NODES-1:0] sel,
  input  logic             din,
  output logic [NODES-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        XP_CLEAR: q <= '0;
        XP_SET:   q <= '1;
        XP_WRITE: q <= (q & ~sel) | (sel & {NODES{din}});
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/xp_route_enc.sv
module xp_route_enc #(
  parameter int X_LINES = 4,
  parameter int Y_LINES = 4,
  localparam int XW     = $clog2(X_LINES),
  localparam int NODES  = X_LINES * Y_LINES,
  localparam int CW     = $clog2(X_LINES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NODES-1:0]      en,
  output logic [Y_LINES*XW-1:0] route_x,
  output logic [Y_LINES-1:0]    route_hit,
  output logic [Y_LINES-1:0]    multi_x
);

  for (genvar y = 0; y < Y_LINES; y++) begin : g_line
    logic [X_LINES-1:0] col;
    logic [XW-1:0]      low_x;
    logic [CW-1:0]      cnt;

    assign col = en[y*X_LINES +: X_LINES];

    // Scan downward so the lowest closed X wins
    always_comb begin
      low_x = '0;
      cnt   = '0;
      for (int x = X_LINES - 1; x >= 0; x--) begin
        if (col[x]) low_x = XW'(x);
        cnt = cnt + CW'(col[x]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        route_x[y*XW +: XW] <= '0;
        route_hit[y]        <= 1'b0;
        multi_x[y]          <= 1'b0;
      end else begin
        route_x[y*XW +: XW] <= low_x;
        route_hit[y]        <= |col;
        multi_x[y]          <= (cnt > CW'(1));
      end
    end
  end

endmodule

// File: rtl/xp_ctrl_mem.sv
module xp_ctrl_mem
  import xp_pkg::*;
#(
  parameter int X_LINES = 4,
  parameter int Y_LINES = 4,
  localparam int XW     = $clog2(X_LINES),
  localparam int YW     = $clog2(Y_LINES),
  localparam int AW     = XW + YW,
  localparam int NODES  = X_LINES * Y_LINES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         addr,
  input  logic                  din,
  input  logic                  strobe,
  input  logic                  gset,
  input  logic                  gclr,
  output logic [NODES-1:0]      en_main,
  output logic [NODES-1:0]      en_mirror,
  output logic [Y_LINES*XW-1:0] route_x,
  output logic [Y_LINES-1:0]    route_hit,
  output logic [Y_LINES-1:0]    multi_x
);

  logic [NODES-1:0] sel;
  logic [NODES-1:0] cells;
  xp_op_e           op;

  assign op = xp_resolve(strobe, gset, gclr);

  xp_addr_dec #(.X_LINES(X_LINES), .Y_LINES(Y_LINES)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  xp_store #(.NODES(NODES)) u_store (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .sel  (sel),
    .din  (din),
    .q    (cells)
  );

  // One stored bit drives the crosspoint in both planes
  assign en_main   = cells;
  assign en_mirror = cells;

  xp_route_enc #(.X_LINES(X_LINES), .Y_LINES(Y_LINES)) u_route (
    .clk       (clk),
    .rst       (rst),
    .en        (cells),
    .route_x   (route_x),
    .route_hit (route_hit),
    .multi_x   (multi_x)
  );

endmodule

// File: rtl/xp_ctrl_mem_chk.sv
module xp_ctrl_mem_chk #(
  parameter int X_LINES = 4,
  parameter int Y_LINES = 4,
  localparam int XW     = $clog2(X_LINES),
  localparam int YW     = $clog2(Y_LINES),
  localparam int AW     = XW + YW,
  localparam int NODES  = X_LINES * Y_LINES
) (
  input logic                  clk,
  input logic                  rst,
  input logic [AW-1:0]         addr,
  input logic                  din,
  input logic                  strobe,
  input logic                  gset,
  input logic                  gclr,
  input logic [NODES-1:0]      en_main,
  input logic [NODES-1:0]      en_mirror,
  input logic [Y_LINES*XW-1:0] route_x,
  input logic [Y_LINES-1:0]    route_hit,
  input logic [Y_LINES-1:0]    multi_x
);

  logic [NODES-1:0] tgt;
  assign tgt = NODES'(1) << (int'(addr[XW +: YW]) * X_LINES + int'(addr[XW-1:0]));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (en_main == '0));

  // R3
  write_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !gset && !gclr) |=> (((en_main & $past(tgt)) != '0) == $past(din)));

  // R4
  write_others_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !gset && !gclr) |=> ((en_main & ~$past(tgt)) == $past(en_main & ~tgt)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !gset && !gclr) |=> $stable(en_main));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    gclr |=> (en_main == '0));

  // R7
  set_all_chk: assert property (@(posedge clk) disable iff (rst)
    (gset && !gclr) |=> (en_main == '1));

  for (genvar y = 0; y < Y_LINES; y++) begin : g_y
    // R8
    hit_lag_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (route_hit[y] == ($past(en_main[y*X_LINES +: X_LINES]) != '0)));
    // R9
    multi_lag_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (multi_x[y] == ($countones($past(en_main[y*X_LINES +: X_LINES])) > 1)));
  end

endmodule

bind xp_ctrl_mem xp_ctrl_mem_chk #(.X_LINES(X_LINES), .Y_LINES(Y_LINES)) u_chk (.*);

// File: tb/tb_xp_ctrl_mem.sv
module tb_xp_ctrl_mem;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        din, strobe, gset, gclr;
  logic [15:0] en_main, en_mirror;
  logic [7:0]  route_x;
  logic [3:0]  route_hit, multi_x;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  xp_ctrl_mem dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .strobe(strobe),
    .gset(gset), .gclr(gclr), .en_main(en_main), .en_mirror(en_mirror),
    .route_x(route_x), .route_hit(route_hit), .multi_x(multi_x)
  );

  // {strobe, gset, gclr, addr, din, expected en_main after the edge}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0001},  // X1Y1
    {1'b1, 1'b0, 1'b0, 4'd5,  1'b1, 16'h0021},  // X2Y2
    {1'b1, 1'b0, 1'b0, 4'd9,  1'b1, 16'h0221},  // X2Y3
    {1'b1, 1'b0, 1'b0, 4'd1,  1'b1, 16'h0223},  // X2Y1: fan-in on Y1
    {1'b0, 1'b0, 1'b0, 4'd3,  1'b1, 16'h0223},  // no strobe
    {1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0222},  // open X1Y1
    {1'b1, 1'b0, 1'b0, 4'd15, 1'b1, 16'h8222},  // X4Y4
    {1'b1, 1'b0, 1'b0, 4'd12, 1'b1, 16'h9222},  // X1Y4: fan-in on Y4
    {1'b1, 1'b0, 1'b0, 4'd12, 1'b0, 16'h8222},  // open X1Y4
    {1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 16'hFFFF},  // set all
    {1'b1, 1'b1, 1'b1, 4'd2,  1'b1, 16'h0000},  // clear beats set and write
    {1'b1, 1'b0, 1'b0, 4'd7,  1'b1, 16'h0080},  // X4Y2
    {1'b1, 1'b1, 1'b0, 4'd3,  1'b0, 16'hFFFF},  // set beats write of 0
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 16'h0000},  // clear
    {1'b1, 1'b0, 1'b0, 4'd6,  1'b1, 16'h0040},  // X3Y2
    {1'b1, 1'b0, 1'b0, 4'd10, 1'b1, 16'h0440}   // X3Y3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    strobe = 1'b0; gset = 1'b0; gclr = 1'b0; din = 1'b0; addr = 4'd0;
  endtask

  // Check route outputs against a given enable pattern (R8, R9)
  task automatic check_route(input logic [15:0] en);
    logic [7:0] ex_x;
    logic [3:0] ex_hit, ex_multi;
    for (int y = 0; y < 4; y++) begin
      int n = 0;
      ex_x[y*2 +: 2] = 2'd0;
      ex_hit[y] = 1'b0;
      for (int x = 3; x >= 0; x--) begin
        if (en[y*4 + x]) begin
          ex_x[y*2 +: 2] = 2'(x);
          ex_hit[y] = 1'b1;
          n++;
        end
      end
      ex_multi[y] = (n > 1);
    end
    check("R8 route_x",   {8'h0, route_x},   {8'h0, ex_x});
    check("R8 route_hit", {12'h0, route_hit}, {12'h0, ex_hit});
    check("R9 multi_x",   {12'h0, multi_x},   {12'h0, ex_multi});
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 en_main", en_main, 16'h0000);
    check("R1 route_hit/multi_x", {8'h0, route_hit, multi_x}, 16'h0000);
    rst = 1'b0;

    // Vector walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      {strobe, gset, gclr, addr, din} = VEC[i][23:16];
      @(posedge clk);
      @(negedge clk);
      idle();
      check($sformatf("R2/R3/R4/R6/R7 vec %0d en_main", i), en_main, VEC[i][15:0]);
      check($sformatf("R5 vec %0d en_mirror", i), en_mirror, VEC[i][15:0]);
      @(posedge clk);
      @(negedge clk);
      check_route(VEC[i][15:0]);
      check($sformatf("R4 vec %0d idle hold", i), en_main, VEC[i][15:0]);
    end

    // Route lag: right after a write the route outputs still show the old state (R8)
    addr = 4'd14; din = 1'b1; strobe = 1'b1;   // X3Y4
    @(posedge clk);
    @(negedge clk);
    idle();
    check("R3 X3Y4 write", en_main, 16'h4440);
    check("R8 route_hit lag", {12'h0, route_hit}, 16'h0006);
    @(posedge clk);
    @(negedge clk);
    check("R8 route_hit updated", {12'h0, route_hit}, 16'h000E);
    check("R8 route_x Y4", {14'h0, route_x[7:6]}, 16'h0002);

    // Mid-run reset (R1)
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run en_main", en_main, 16'h0000);
    check("R1 mid-run en_mirror", en_mirror, 16'h0000);
    check("R1 mid-run route_hit/multi_x", {8'h0, route_hit, multi_x}, 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule